// File: doc/BRIEF.md
# DAC Conversion Trigger Controller

This block is the digital front end of a single-channel digital-to-analog converter. A small register-write port loads four registers: a control word, a pending sample, a one-shot software trigger and a settling interval. The block decides the cycle in which the pending sample moves into the output register that feeds the converter. After that it holds a busy flag until the programmed settling interval has run out.

There are two start policies. In direct mode, every write to the sample register starts a conversion. In triggered mode, one selected source starts the conversion. The sources are the software trigger bit, an asynchronous start pin qualified in one of four ways, one of four timer event lines, or one of two PWM event lines. Any start that arrives while the settling interval runs is dropped. A one-cycle completion pulse marks the end of each interval.

Top module: `dac_trig_ctrl`

## Requirements
- R1: After reset `dac_data` is 0, and `busy` and `done` are both low.
- R2: Register addresses are: 0 control, 1 sample, 2 software trigger, 3 settling interval. In the control word, bit 0 is the converter enable and bit 4 is the trigger enable. With trigger enable at 0, writing the sample register starts a conversion. The new sample appears on `dac_data` after the second rising edge, counting the write edge as the first.
- R3: With trigger enable at 1, a write to the sample register alone starts nothing, and `dac_data` keeps its value.
- R4: Writing 1 to bit 0 of register 2 in triggered mode with source code 0 starts exactly one conversion. The bit clears itself one cycle later.
- R5: The source code sits in control bits 11:8. Codes 1 (pin low) and 2 (pin high) are level modes. While the synchronized pin is at the active level, a new conversion starts every time the block is idle.
- R6: Codes 3 (pin falling) and 4 (rising) are edge modes. The pin passes through a two-flop synchronizer, and each matching transition starts exactly one conversion.
- R7: Codes 5 to 8 select `tmr_evt[0]` to `tmr_evt[3]`, and codes 9 and 10 select `pwm_evt[0]` and `pwm_evt[1]`. A pulse on any line that is not selected starts nothing.
- R8: A start loads the settling interval N (register 3, bits 9:0). `busy` is then high for exactly N cycles. When N is 0, `busy` never rises.
- R9: Starts requested while `busy` is high are ignored, and `dac_data` does not change while `busy` is high.
- R10: `done` is high for one cycle when `busy` falls, or right after a start with N = 0. `done` is never high together with `busy`.
- R11: With control bit 0 at 0, no source starts a conversion and `dac_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Register write data |
| ext_start | input | 1 | Asynchronous external start pin |
| tmr_evt | input | 4 | Timer event lines, one per timer |
| pwm_evt | input | 2 | PWM event lines |
| dac_data | output | DATA_W | Sample driven to the converter |
| busy | output | 1 | Settling interval running |
| done | output | 1 | One-cycle settling-complete pulse |

## Verification
The end of a settling interval and the acceptance of the next start can fall in the same cycle. In that cycle `done` is high and the idle block takes a level-mode request at the following edge. The bench provokes this by holding the pin at its active level in pin-high mode with a short interval. It then waits for `done` and requires `busy` to be low in that cycle and high in the next one. It also requires the total number of completions to show back-to-back conversions. A second case sends a software trigger during a long interval and requires the sample and the completion count to stay unchanged.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

  localparam int NUM_TMR = 4;
  localparam int NUM_PWM = 2;
  localparam int SRC_W   = 4;

  // register addresses
  localparam logic [1:0] RA_CTL    = 2'd0;
  localparam logic [1:0] RA_DATA   = 2'd1;
  localparam logic [1:0] RA_SWTRG  = 2'd2;
  localparam logic [1:0] RA_SETTLE = 2'd3;

  // control word bit positions
  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_TRGEN_BIT = 4;
  localparam int CTL_SRC_LSB   = 8;

  // source codes; timer and PWM codes follow in order
  localparam logic [SRC_W-1:0] SRC_SW       = 4'd0;
  localparam logic [SRC_W-1:0] SRC_PIN_LOW  = 4'd1;
  localparam logic [SRC_W-1:0] SRC_PIN_HIGH = 4'd2;
  localparam logic [SRC_W-1:0] SRC_PIN_FALL = 4'd3;
  localparam logic [SRC_W-1:0] SRC_PIN_RISE = 4'd4;
  localparam int SRC_TMR_BASE = 5;
  localparam int SRC_PWM_BASE = SRC_TMR_BASE + NUM_TMR;

  typedef struct packed {
    logic             en;
    logic             trg_en;
    logic [SRC_W-1:0] src;
  } ctl_t;

endpackage

// File: rtl/dac_regs.sv
module dac_regs
  import dac_trig_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output ctl_t                ctl,
  output logic [DATA_W-1:0]   sample_q,
  output logic [SETTLE_W-1:0] settle_q,
  output logic                sw_trig,
  output logic                sample_wr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      sample_q  <= '0;
      settle_q  <= '0;
      sw_trig   <= 1'b0;
      sample_wr <= 1'b0;
    end else begin
      sw_trig   <= 1'b0;
      sample_wr <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          RA_CTL: begin
            ctl.en     <= wr_data[CTL_EN_BIT];
            ctl.trg_en <= wr_data[CTL_TRGEN_BIT];
            ctl.src    <= wr_data[CTL_SRC_LSB +: SRC_W];
          end
          RA_DATA: begin
            sample_q  <= wr_data;
            sample_wr <= 1'b1;
          end
          RA_SWTRG:  sw_trig  <= wr_data[0];
          default:   settle_q <= wr_data[SETTLE_W-1:0];
        endcase
      end
    end
  end

  // R4: the one-shot bit only follows a write of 1 to the trigger register
  a_r4_sw_from_write: assert property (@(posedge clk) disable iff (rst)
    sw_trig |-> $past(wr_en && wr_addr == RA_SWTRG && wr_data[0]));

endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
  import dac_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  ctl_t               ctl,
  input  logic               sw_trig,
  input  logic               sample_wr,
  input  logic               ext_pin,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic [NUM_PWM-1:0] pwm_evt,
  output logic               req
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev;
  logic                   pin_now;
  logic                   rise_det;
  logic                   fall_det;
  logic                   hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '0;
      pin_prev <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      pin_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_now  = sync_q[SYNC_STAGES-1];
  assign rise_det = pin_now & ~pin_prev;
  assign fall_det = ~pin_now & pin_prev;

  always_comb begin
    hit = 1'b0;
    case (ctl.src)
      SRC_SW:       hit = sw_trig;
      SRC_PIN_LOW:  hit = ~pin_now;
      SRC_PIN_HIGH: hit = pin_now;
      SRC_PIN_FALL: hit = fall_det;
      SRC_PIN_RISE: hit = rise_det;
      default:      hit = 1'b0;
    endcase
    for (int i = 0; i < NUM_TMR; i++)
      if (ctl.src == SRC_W'(SRC_TMR_BASE + i)) hit = tmr_evt[i];
    for (int j = 0; j < NUM_PWM; j++)
      if (ctl.src == SRC_W'(SRC_PWM_BASE + j)) hit = pwm_evt[j];
  end

  assign req = ctl.en & (ctl.trg_en ? hit : sample_wr);

  // R6: each detected transition lasts a single cycle
  a_r6_rise_single: assert property (@(posedge clk) disable iff (rst)
    rise_det |=> !rise_det);
  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_det |=> !fall_det);

endmodule

// File: rtl/dac_settle.sv
module dac_settle #(
  parameter int DATA_W   = 12,
  parameter int SETTLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [DATA_W-1:0]   sample,
  input  logic [SETTLE_W-1:0] settle_n,
  output logic [DATA_W-1:0]   dac_q,
  output logic                busy_q,
  output logic                done_q
);

  logic [SETTLE_W-1:0] cnt_q;
  logic                start;

  assign start = req & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        dac_q  <= sample;
        cnt_q  <= settle_n;
        busy_q <= (settle_n != '0);
        done_q <= (settle_n == '0);
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == SETTLE_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R9: the output sample is frozen while settling
  a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(dac_q));
  // R10: completion never overlaps busy
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R8: a running interval always has cycles left
  a_r8_count_live: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q != '0);

endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
  import dac_trig_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SETTLE_W    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               ext_start,
  input  logic [NUM_TMR-1:0] tmr_evt,
  input  logic [NUM_PWM-1:0] pwm_evt,
  output logic [DATA_W-1:0]  dac_data,
  output logic               busy,
  output logic               done
);

  ctl_t                ctl;
  logic [DATA_W-1:0]   sample_q;
  logic [SETTLE_W-1:0] settle_q;
  logic                sw_trig;
  logic                sample_wr;
  logic                req;

  dac_regs #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl(ctl), .sample_q(sample_q), .settle_q(settle_q),
    .sw_trig(sw_trig), .sample_wr(sample_wr)
  );

  dac_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst(rst), .ctl(ctl), .sw_trig(sw_trig), .sample_wr(sample_wr),
    .ext_pin(ext_start), .tmr_evt(tmr_evt), .pwm_evt(pwm_evt), .req(req)
  );

  dac_settle #(.DATA_W(DATA_W), .SETTLE_W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .req(req), .sample(sample_q), .settle_n(settle_q),
    .dac_q(dac_data), .busy_q(busy), .done_q(done)
  );

  // R11: a disabled converter never takes a new sample
  a_r11_off_holds: assert property (@(posedge clk) disable iff (rst)
    !ctl.en |=> $stable(dac_data));

endmodule

// File: tb/tb_dac_trig_ctrl.sv
module tb_dac_trig_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic          ext_start;
  logic [3:0]    tmr_evt;
  logic [1:0]    pwm_evt;
  logic [DW-1:0] dac_data;
  logic          busy;
  logic          done;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  // {source code, event line 0-3 timer 4-5 pwm, expected start}
  localparam logic [11:0] VEC [9] = '{
    {4'd5,  4'd0, 4'd1}, {4'd6,  4'd1, 4'd1}, {4'd7, 4'd3, 4'd0},
    {4'd8,  4'd3, 4'd1}, {4'd9,  4'd4, 4'd1}, {4'd10, 4'd5, 4'd1},
    {4'd10, 4'd4, 4'd0}, {4'd5,  4'd2, 4'd0}, {4'd6, 4'd0, 4'd0}
  };

  dac_trig_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_start(ext_start), .tmr_evt(tmr_evt), .pwm_evt(pwm_evt),
    .dac_data(dac_data), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (!rst && done) done_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctlw(input int en, input int trg, input int src);
    return en | (trg << 4) | (src << 8);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int snap;
    int bcnt;
    int exp_dac;
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ext_start = 1'b0; tmr_evt = '0; pwm_evt = '0;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk("R1 dac", int'(dac_data), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);

    // R2 direct mode timing
    wr(3, 2);
    wr(0, ctlw(1, 0, 0));
    wr(1, 'h123);
    chk("R2 not yet", int'(dac_data), 0);
    tick(1);
    chk("R2 sample", int'(dac_data), 'h123);
    chk("R8 busy after start", int'(busy), 1);
    tick(4);

    // R8 busy length N=5
    wr(3, 5);
    snap = done_cnt;
    wr(1, 'h0AA);
    bcnt = 0;
    for (int i = 0; i < 12; i++) begin tick(1); if (busy) bcnt++; end
    chk("R8 busy cycles N=5", bcnt, 5);
    chk("R10 one done", done_cnt - snap, 1);

    // R8/R10 with N=0
    wr(3, 0);
    snap = done_cnt;
    wr(1, 'h055);
    bcnt = 0;
    for (int i = 0; i < 4; i++) begin tick(1); if (busy) bcnt++; end
    chk("R8 busy cycles N=0", bcnt, 0);
    chk("R10 done N=0", done_cnt - snap, 1);
    chk("R2 sample N=0", int'(dac_data), 'h055);
    wr(3, 2);

    // R11 disabled
    snap = done_cnt;
    wr(0, 0);
    wr(1, 'h3FF);
    tick(4);
    chk("R11 sample held", int'(dac_data), 'h055);
    chk("R11 no done", done_cnt - snap, 0);

    // R3 triggered mode, write alone
    wr(0, ctlw(1, 1, 0));
    wr(1, 'h111);
    tick(4);
    chk("R3 write ignored", int'(dac_data), 'h055);

    // R4 software trigger, one conversion
    snap = done_cnt;
    wr(2, 1);
    tick(8);
    chk("R4 sample", int'(dac_data), 'h111);
    chk("R4 single conversion", done_cnt - snap, 1);

    // R9 trigger while busy ignored
    wr(3, 10);
    wr(1, 'h222);
    snap = done_cnt;
    wr(2, 1);
    tick(2);
    chk("R9 busy", int'(busy), 1);
    wr(1, 'h333);
    wr(2, 1);
    tick(15);
    chk("R9 sample kept", int'(dac_data), 'h222);
    chk("R9 one done", done_cnt - snap, 1);

    // R7 timer and PWM selection table
    wr(3, 1);
    exp_dac = 'h222;
    for (int i = 0; i < 9; i++) begin
      int line;
      wr(0, ctlw(1, 1, int'(VEC[i][11:8])));
      wr(1, 'h400 + i);
      tick(1);
      line = int'(VEC[i][7:4]);
      if (line < 4) tmr_evt[line] = 1'b1; else pwm_evt[line-4] = 1'b1;
      tick(1);
      tmr_evt = '0; pwm_evt = '0;
      tick(3);
      if (VEC[i][0]) exp_dac = 'h400 + i;
      chk("R7 source table", int'(dac_data), exp_dac);
    end

    // R5 level high, done and next start in the same cycle
    wr(3, 3);
    wr(1, 'h5A5);
    wr(0, ctlw(1, 1, 2));
    snap = done_cnt;
    ext_start = 1'b1;
    tick(4);
    for (int i = 0; i < 20; i++) begin
      if (done) break;
      tick(1);
    end
    chk("R10 done seen", int'(done), 1);
    chk("R10 idle in done cycle", int'(busy), 0);
    tick(1);
    chk("R5 restart after done", int'(busy), 1);
    tick(10);
    ext_start = 1'b0;
    tick(8);
    chk("R5 repeated conversions", (done_cnt - snap) >= 4 ? 1 : 0, 1);
    chk("R5 sample", int'(dac_data), 'h5A5);

    // R5 level low
    wr(0, ctlw(1, 1, 1));
    snap = done_cnt;
    tick(12);
    chk("R5 low repeats", (done_cnt - snap) >= 2 ? 1 : 0, 1);
    ext_start = 1'b1;
    tick(8);
    snap = done_cnt;
    tick(12);
    chk("R5 low inactive", done_cnt - snap, 0);

    // R6 rising edge
    wr(0, ctlw(1, 1, 4));
    tick(4);
    snap = done_cnt;
    ext_start = 1'b0;
    tick(6);
    chk("R6 no rise on fall", done_cnt - snap, 0);
    ext_start = 1'b1;
    tick(15);
    chk("R6 one per rise", done_cnt - snap, 1);

    // R6 falling edge
    wr(0, ctlw(1, 1, 3));
    wr(1, 'h0F0);
    snap = done_cnt;
    ext_start = 1'b0;
    tick(15);
    chk("R6 one per fall", done_cnt - snap, 1);
    chk("R6 sample", int'(dac_data), 'h0F0);
    ext_start = 1'b1;
    tick(10);
    chk("R6 rise ignored in fall mode", done_cnt - snap, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule